// File: doc/BRIEF.md
# Transmit Start Threshold Controller

This block sits beside a MAC transmit FIFO and decides the cycle in which the serializer may begin sending the frame being loaded into it. A frame is announced by a one-cycle `frameStart` pulse. On that pulse the block captures a 2-bit threshold code, a store-and-forward flag and a speed-mode flag. It keeps those values for the whole frame. It then compares the running byte count of the frame against the selected threshold and issues a single `txStart` pulse.

The speed-mode flag picks one of two threshold tables: a larger one for 100 Mb/s and a tighter one for 10 Mb/s. Store-and-forward overrides both tables and waits for the whole frame. While the frame is being sent, the block watches the FIFO. If the FIFO runs dry before the last byte has been loaded, it reports an underflow and abandons the frame. The block also raises a one-cycle early-transmit event once the complete frame sits in the FIFO.

Top module: `txs_start_ctl`

## Requirements
- R1: After reset, `txStart`, `txUnderflow` and `earlyTx` are low and the block is idle, so no byte count starts a transmission before a `frameStart` pulse.
- R2: With `slowMode`=0 and `storeFwd`=0, the thresholds are 128, 256, 512 and 1024 bytes for `thrCode` 0, 1, 2 and 3. `txStart` pulses in the cycle after the first cycle in which `loadCount` is strictly greater than the threshold. A count equal to the threshold does not start.
- R3: With `slowMode`=1 and `storeFwd`=0, the thresholds are 72, 96, 128 and 160 bytes for `thrCode` 0, 1, 2 and 3, with the same strict comparison and timing as R2.
- R4: With `storeFwd`=1, `thrCode` and `slowMode` are ignored. `txStart` pulses only in the cycle after `frameLoaded` is first seen high, however large `loadCount` is.
- R5: A frame whose `frameLoaded` rises while `loadCount` is still at or below the threshold starts in the cycle after `frameLoaded` is seen.
- R6: `txStart` is one cycle wide and occurs at most once per frame. A `frameStart` pulse that arrives while a frame is still waiting or sending is ignored.
- R7: `thrCode`, `storeFwd` and `slowMode` are sampled only on the accepted `frameStart` cycle. Changing them later in the frame has no effect on when it starts.
- R8: While sending, if `fifoEmpty` is high and `frameLoaded` is low, `txUnderflow` pulses for one cycle in the next cycle and the block returns to idle. `fifoEmpty` with `frameLoaded` high raises no underflow. `txDone` while sending returns the block to idle.
- R9: `earlyTx` pulses for one cycle, in the cycle after `frameLoaded` is first seen high during a waiting or sending frame, and only once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse marking the start of a new frame |
| thrCode | input | 2 | Threshold table index |
| storeFwd | input | 1 | Wait for the whole frame before starting |
| slowMode | input | 1 | 1 selects the 10 Mb/s table, 0 the 100 Mb/s table |
| loadCount | input | CNT_W | Bytes of the current frame loaded into the FIFO |
| frameLoaded | input | 1 | Whole frame is in the FIFO |
| fifoEmpty | input | 1 | FIFO holds no bytes |
| txDone | input | 1 | Serializer finished the frame |
| txStart | output | 1 | One-cycle start-transmit pulse |
| txUnderflow | output | 1 | One-cycle underflow event |
| earlyTx | output | 1 | One-cycle early-transmit event |

## Verification
The bench builds the block with `CNT_W`=11. This is the narrowest counter that can hold a count of 1025, so the largest 100 Mb/s threshold can be probed on both sides of its boundary, and a 1500-byte frame can be held under store-and-forward. Every threshold in both tables is exercised at exactly the threshold and at one byte above it. Directed scenarios cover short frames, mid-frame configuration changes, repeated and stray frame pulses, and FIFO drain with and without the frame fully loaded.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int THR_W = 11;
  localparam int FAST_BASE = 128;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} txsState_t;

  typedef struct packed {
    logic latchCfg;
    logic waiting;
  } txsStrobe_t;

  function automatic logic [THR_W-1:0] thrBytes(input logic [1:0] code, input logic slow);
    logic [THR_W-1:0] r;
    if (slow) begin
      case (code)
        2'd0: r = THR_W'(72);
        2'd1: r = THR_W'(96);
        2'd2: r = THR_W'(128);
        default: r = THR_W'(160);
      endcase
    end else begin
      r = THR_W'(FAST_BASE) << code;
    end
    return r;
  endfunction
endpackage

// File: rtl/txs_dpath.sv
module txs_dpath
  import txs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  txsStrobe_t       strobe,
  input  logic [1:0]       thrCode,
  input  logic             storeFwd,
  input  logic             slowMode,
  input  logic [CNT_W-1:0] loadCount,
  input  logic             frameLoaded,
  output logic             startOk
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [1:0] cfgCode;
  logic       cfgSf;
  logic       cfgSlow;
  logic [CMP_W-1:0] cntExt;
  logic [CMP_W-1:0] thrExt;
  logic       aboveThr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCode <= 2'd0;
      cfgSf   <= 1'b0;
      cfgSlow <= 1'b0;
    end else if (strobe.latchCfg) begin
      cfgCode <= thrCode;
      cfgSf   <= storeFwd;
      cfgSlow <= slowMode;
    end
  end

  always_comb begin
    cntExt = '0;
    thrExt = '0;
    cntExt[CNT_W-1:0] = loadCount;
    thrExt[THR_W-1:0] = thrBytes(cfgCode, cfgSlow);
    aboveThr = cntExt > thrExt;
    startOk  = strobe.waiting && (frameLoaded || (!cfgSf && aboveThr));
  end
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       frameLoaded,
  input  logic       fifoEmpty,
  input  logic       txDone,
  input  logic       startOk,
  output txsStrobe_t strobe,
  output logic       txStart,
  output logic       txUnderflow,
  output logic       earlyTx
);
  txsState_t state;
  logic      earlySent;

  always_comb begin
    strobe.latchCfg = (state == ST_IDLE) && frameStart;
    strobe.waiting  = (state == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      txStart     <= 1'b0;
      txUnderflow <= 1'b0;
      earlyTx     <= 1'b0;
      earlySent   <= 1'b0;
    end else begin
      txStart     <= 1'b0;
      txUnderflow <= 1'b0;
      earlyTx     <= 1'b0;
      case (state)
        ST_IDLE: if (frameStart) begin
          state     <= ST_WAIT;
          earlySent <= 1'b0;
        end
        ST_WAIT: if (startOk) begin
          txStart <= 1'b1;
          state   <= ST_SEND;
        end
        ST_SEND: begin
          if (txDone) begin
            state <= ST_IDLE;
          end else if (fifoEmpty && !frameLoaded) begin
            txUnderflow <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (state != ST_IDLE && frameLoaded && !earlySent) begin
        earlyTx   <= 1'b1;
        earlySent <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txs_start_ctl.sv
module txs_start_ctl
  import txs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [1:0]       thrCode,
  input  logic             storeFwd,
  input  logic             slowMode,
  input  logic [CNT_W-1:0] loadCount,
  input  logic             frameLoaded,
  input  logic             fifoEmpty,
  input  logic             txDone,
  output logic             txStart,
  output logic             txUnderflow,
  output logic             earlyTx
);
  txsStrobe_t strobe;
  logic       startOk;

  txs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameLoaded(frameLoaded),
    .fifoEmpty(fifoEmpty), .txDone(txDone), .startOk(startOk), .strobe(strobe),
    .txStart(txStart), .txUnderflow(txUnderflow), .earlyTx(earlyTx)
  );

  txs_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .thrCode(thrCode), .storeFwd(storeFwd),
    .slowMode(slowMode), .loadCount(loadCount), .frameLoaded(frameLoaded),
    .startOk(startOk)
  );
endmodule

// File: rtl/txs_start_chk.sv
module txs_start_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] loadCount,
  input logic             frameLoaded,
  input logic             fifoEmpty,
  input logic             txStart,
  input logic             txUnderflow,
  input logic             earlyTx
);
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  a_r8_uf_single: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow |=> !txUnderflow);

  a_r8_uf_cause: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow |-> ($past(fifoEmpty) && !$past(frameLoaded)));

  a_r9_early_single: assert property (@(posedge clk) disable iff (!rstN)
    earlyTx |=> !earlyTx);

  a_r9_early_cause: assert property (@(posedge clk) disable iff (!rstN)
    earlyTx |-> $past(frameLoaded));

  a_r5_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> ($past(frameLoaded) || ($past(loadCount) > CNT_W'(72))));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txStart, txUnderflow}));
endmodule

bind txs_start_ctl txs_start_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadCount(loadCount), .frameLoaded(frameLoaded),
  .fifoEmpty(fifoEmpty), .txStart(txStart), .txUnderflow(txUnderflow), .earlyTx(earlyTx)
);

// File: tb/txs_start_ctl_test.sv
module txs_start_ctl_test;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic [1:0] thrCode = 2'd0;
  logic storeFwd = 1'b0, slowMode = 1'b0;
  logic [CW-1:0] loadCount = '0;
  logic frameLoaded = 1'b0, fifoEmpty = 1'b0, txDone = 1'b0;
  logic txStart, txUnderflow, earlyTx;
  int nTests = 0, nFails = 0;

  always #10 clk = ~clk;

  txs_start_ctl #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .thrCode(thrCode),
    .storeFwd(storeFwd), .slowMode(slowMode), .loadCount(loadCount),
    .frameLoaded(frameLoaded), .fifoEmpty(fifoEmpty), .txDone(txDone),
    .txStart(txStart), .txUnderflow(txUnderflow), .earlyTx(earlyTx)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    frameStart = 0; loadCount = '0; frameLoaded = 0; fifoEmpty = 0; txDone = 0;
  endtask

  task automatic beginFrame(input logic [1:0] c, input logic sf, input logic sl);
    thrCode = c; storeFwd = sf; slowMode = sl; frameStart = 1;
    tick();
    frameStart = 0;
  endtask

  task automatic endFrame();
    txDone = 1; tick(); txDone = 0; idleInputs(); tick();
  endtask

  task automatic testReset();
    chk("R1 txStart", txStart, 0);
    chk("R1 txUnderflow", txUnderflow, 0);
    chk("R1 earlyTx", earlyTx, 0);
    loadCount = 11'd2000; tick(); tick();
    chk("R1 no start idle", txStart, 0);
    idleInputs(); tick();
  endtask

  task automatic testThreshold(input logic sl, input logic [1:0] c, input int thr, input string req);
    beginFrame(c, 0, sl);
    loadCount = CW'(thr); tick();
    chk({req, " equal no start"}, txStart, 0);
    loadCount = CW'(thr + 1); tick();
    chk({req, " above starts"}, txStart, 1);
    tick();
    chk({req, " one-cycle"}, txStart, 0);
    endFrame();
  endtask

  task automatic testStoreFwd();
    beginFrame(2'd0, 1, 0);
    loadCount = 11'd1500; tick(); tick();
    chk("R4 no start before loaded", txStart, 0);
    frameLoaded = 1; tick();
    chk("R4 start on loaded", txStart, 1);
    chk("R9 early with loaded", earlyTx, 1);
    endFrame();
  endtask

  task automatic testShort();
    beginFrame(2'd3, 0, 1);
    loadCount = 11'd40; tick();
    chk("R5 short not yet", txStart, 0);
    frameLoaded = 1; tick();
    chk("R5 short starts", txStart, 1);
    chk("R9 early short", earlyTx, 1);
    tick(); tick();
    chk("R9 early once", earlyTx, 0);
    endFrame();
  endtask

  task automatic testCfgHold();
    beginFrame(2'd0, 0, 0);
    thrCode = 2'd3; storeFwd = 1; slowMode = 1;
    loadCount = 11'd129; tick();
    chk("R7 held config starts", txStart, 1);
    endFrame();
  endtask

  task automatic testOnce();
    beginFrame(2'd0, 0, 1);
    loadCount = 11'd100; tick();
    chk("R6 start", txStart, 1);
    frameStart = 1; tick(); frameStart = 0;
    chk("R6 no second start", txStart, 0);
    tick();
    chk("R6 stray pulse ignored", txStart, 0);
    endFrame();
    loadCount = 11'd2000; tick(); tick();
    chk("R6 idle after done", txStart, 0);
    idleInputs(); tick();
  endtask

  task automatic testUnderflow();
    beginFrame(2'd0, 0, 0);
    loadCount = 11'd200; tick();
    chk("R8 started", txStart, 1);
    fifoEmpty = 1; tick();
    chk("R8 underflow", txUnderflow, 1);
    fifoEmpty = 0; tick();
    chk("R8 one-cycle", txUnderflow, 0);
    tick();
    chk("R8 back idle no start", txStart, 0);
    idleInputs(); tick();
    beginFrame(2'd0, 0, 0);
    loadCount = 11'd200; tick();
    frameLoaded = 1; fifoEmpty = 1; tick();
    chk("R8 no underflow when loaded", txUnderflow, 0);
    tick();
    chk("R8 still none", txUnderflow, 0);
    endFrame();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1; tick();
    testReset();
    testThreshold(0, 2'd0, 128, "R2 c0");
    testThreshold(0, 2'd1, 256, "R2 c1");
    testThreshold(0, 2'd2, 512, "R2 c2");
    testThreshold(0, 2'd3, 1024, "R2 c3");
    testThreshold(1, 2'd0, 72, "R3 c0");
    testThreshold(1, 2'd1, 96, "R3 c1");
    testThreshold(1, 2'd2, 128, "R3 c2");
    testThreshold(1, 2'd3, 160, "R3 c3");
    testStoreFwd();
    testShort();
    testCfgHold();
    testOnce();
    testUnderflow();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule